// File: doc/BRIEF.md
# Write-Through Set-Associative Data Cache

This block sits between a load/store unit and a memory port that moves one 32-bit word per beat. It serves byte, halfword and word loads and stores in big-endian lane order. Loads that hit return data from the cache. Loads that miss refill the chosen way word by word, starting with the word that was asked for. Every store goes to memory first. A cacheable store then either merges into the cached word or, on a miss, allocates the line by refilling it. A single-address invalidate command drops a line. Two inputs, sampled with each request, turn caching off altogether or for that one access.

Both the request path and the response path use a valid/ready handshake. A request is taken on a cycle where `req_valid` and `req_ready` are both high, and only one request is in flight at a time. `rsp_valid` stays high with stable data until `rsp_ready` is seen. On the memory side, `mem_req_valid` stays high and its address, enable and data stay unchanged until `mem_req_ready` is high. Read data is taken from `mem_rdata` in the cycle of that handshake. A separate age-counter unit picks the way to replace.

Top module: `wt_dcache`

## Requirements
- R1: The line address is the byte address divided by the line size (LINE_WORDS*4 bytes). The set is the line address modulo SETS and the tag is the line address divided by SETS. An access to a line already held in a valid way is a hit. SETS, WAYS and LINE_WORDS are powers of two, each at least 2.
- R2: `req_size` 0 is a byte, 1 a halfword and 2 a word. Byte offset 0 lies in bits 31:24 and halfword offset 0 in bits 31:16. Load results come back right-aligned in `rsp_rdata`, with the upper bits zero.
- R3: On a cacheable load miss, the victim way receives LINE_WORDS memory reads. The first read is to the requested word, and each later read is to the next word, wrapping within the line. The tag is marked valid after the last beat.
- R4: When `cache_en` is 0 or `cache_inhibit` is 1, a load makes one word read from memory and returns its lanes. The contents of the cache do not change.
- R5: Every store writes memory once. Byte enables follow R2: bit 3 of `mem_be` covers bits 31:24. A cacheable store hit replaces only the addressed lanes of the cached word.
- R6: A cacheable store miss writes memory and then refills the victim way as in R3, so the line is allocated.
- R7: A store with caching off writes memory only, and any cached copy keeps its old value.
- R8: Each way has an age from 0 to AGE_STATES-1, and reset sets every age to 0. A hit sets the way's age to the maximum and lowers by one every way in the set whose age was above the old age of the hit way. A fill lowers by one every nonzero age in the set and sets the filled way to the maximum. The victim is the lowest-numbered way whose age is below the maximum, taking the smallest such age. If no age is below the maximum, the victim is way 0.
- R9: An invalidate (`req_op` 2) with caching on that hits clears that way and its age. An invalidate that misses changes nothing.
- R10: An invalidate issued while `cache_en` is 0 clears every way of the indexed set.
- R11: Counting clock edges from the accepting edge to the edge that raises `rsp_valid`, with memory always ready, the latencies are as follows. Load hit: LD_HIT_LAT+2. Load miss: LINE_WORDS+LD_MISS_LAT+2. Uncached load: 3. Store hit: ST_HIT_LAT+3. Store miss: LINE_WORDS+ST_MISS_LAT+3. Uncached store: 3. Invalidate: 2.
- R12: `req_ready` is high only when no request is in flight, and `busy` is high while one is. A held memory request keeps its address until it is accepted. A held response keeps its data until it is accepted.
- R13: After reset, `busy`, `rsp_valid` and `mem_req_valid` are 0, `req_ready` is 1, and every line is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cache_en | input | 1 | Caching enabled, sampled with the request |
| cache_inhibit | input | 1 | Bypass the cache for this request |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_op | input | 2 | 0 load, 1 store, 2 invalidate |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_addr | input | AW | Byte address |
| req_wdata | input | 32 | Store data, right-aligned |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken |
| rsp_rdata | output | 32 | Load result, right-aligned |
| busy | output | 1 | A request is in flight |
| mem_req_valid | output | 1 | Memory beat request |
| mem_req_ready | input | 1 | Memory accepts the beat |
| mem_we | output | 1 | 1 for a write beat |
| mem_addr | output | AW | Word-aligned memory address |
| mem_be | output | 4 | Write lane enables, bit 3 = bits 31:24 |
| mem_wdata | output | 32 | Write data placed in its lanes |
| mem_rdata | input | 32 | Read data, valid in the handshake cycle |

## Verification
Each result has a fixed due cycle, given by the edge counts in R11. The bench drives a request at a falling edge and then counts rising edges. It samples one time unit after each edge, so it sees the first edge after which `rsp_valid` is high, and compares that count with the expected one. Memory effects are checked in the bench's own memory model, which applies a write at the falling edge that holds the handshake. This means a store's effect is visible before its response comes back. The refill order is taken from the handshake addresses logged at falling edges. During that run the memory is stalled on alternate cycles, so the held-request rule is exercised as well.

// File: rtl/wtdc_pkg.sv
`timescale 1ns/1ps
package wtdc_pkg;
  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2} size_e;
  typedef enum logic [1:0] {OP_LOAD = 2'd0, OP_STORE = 2'd1, OP_INV = 2'd2} op_e;

  // lane enables, bit 3 = bits 31:24 (big-endian offset 0)
  function automatic logic [3:0] lanes(input logic [1:0] sz, input logic [1:0] off);
    case (sz)
      SZ_BYTE: lanes = 4'b1000 >> off;
      SZ_HALF: lanes = off[1] ? 4'b0011 : 4'b1100;
      default: lanes = 4'b1111;
    endcase
  endfunction

  function automatic logic [31:0] place(input logic [1:0] sz, input logic [1:0] off,
                                        input logic [31:0] d);
    logic [4:0] sh;
    sh = {~off, 3'b000};
    case (sz)
      SZ_BYTE: place = {24'd0, d[7:0]} << sh;
      SZ_HALF: place = off[1] ? {16'd0, d[15:0]} : {d[15:0], 16'd0};
      default: place = d;
    endcase
  endfunction

  function automatic logic [31:0] extract(input logic [1:0] sz, input logic [1:0] off,
                                          input logic [31:0] w);
    logic [4:0] sh;
    sh = {~off, 3'b000};
    case (sz)
      SZ_BYTE: extract = {24'd0, w[sh +: 8]};
      SZ_HALF: extract = off[1] ? {16'd0, w[15:0]} : {16'd0, w[31:16]};
      default: extract = w;
    endcase
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] old_w, input logic [31:0] new_w,
                                        input logic [3:0] be);
    for (int i = 0; i < 4; i++) merge[8*i +: 8] = be[i] ? new_w[8*i +: 8] : old_w[8*i +: 8];
  endfunction
endpackage

// File: rtl/wtdc_array.sv
`timescale 1ns/1ps
module wtdc_array #(
  parameter int WAYS  = 2,
  parameter int SETS  = 4,
  parameter int WORDS = 4,
  parameter int TAG_W = 26,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int WRD_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] set_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic [WAY_W-1:0] rd_way_i,
  input  logic [WRD_W-1:0] rd_word_i,
  output logic             hit_o,
  output logic [WAY_W-1:0] hit_way_o,
  output logic [31:0]      rd_data_o,
  input  logic             dw_en_i,
  input  logic [WAY_W-1:0] dw_way_i,
  input  logic [WRD_W-1:0] dw_word_i,
  input  logic [31:0]      dw_data_i,
  input  logic             tw_en_i,
  input  logic             tw_valid_i,
  input  logic [WAY_W-1:0] tw_way_i,
  input  logic             clr_set_i
);
  logic [WAYS-1:0]  valid_q [SETS];
  logic [TAG_W-1:0] tag_q   [SETS][WAYS];
  logic [31:0]      data_q  [SETS][WAYS][WORDS];
  logic [WAYS-1:0]  match;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = valid_q[set_i][w] && (tag_q[set_i][w] == tag_i);
  end

  always_comb begin
    hit_way_o = '0;
    for (int w = 0; w < WAYS; w++) if (match[w]) hit_way_o = WAY_W'(w);
  end
  assign hit_o     = |match;
  assign rd_data_o = data_q[set_i][rd_way_i][rd_word_i];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
    end else if (clr_set_i) begin
      valid_q[set_i] <= '0;
    end else if (tw_en_i) begin
      valid_q[set_i][tw_way_i] <= tw_valid_i;
    end
  end

  always_ff @(posedge clk) begin
    if (tw_en_i && tw_valid_i) tag_q[set_i][tw_way_i] <= tag_i;
    if (dw_en_i) data_q[set_i][dw_way_i][dw_word_i] <= dw_data_i;
  end
endmodule

// File: rtl/wtdc_age.sv
`timescale 1ns/1ps
module wtdc_age #(
  parameter int WAYS   = 2,
  parameter int SETS   = 4,
  parameter int STATES = 4,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int AGE_W = $clog2(STATES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] set_i,
  input  logic [WAY_W-1:0] way_i,
  input  logic             touch_i,
  input  logic             fill_i,
  input  logic             clr_way_i,
  input  logic             clr_set_i,
  output logic [WAY_W-1:0] victim_o
);
  localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(STATES - 1);
  logic [AGE_W-1:0] age_q [SETS][WAYS];
  logic [AGE_W-1:0] best;

  always_comb begin
    best     = AGE_MAX;
    victim_o = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (age_q[set_i][w] < best) begin
        best     = age_q[set_i][w];
        victim_o = WAY_W'(w);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) age_q[s][w] <= '0;
    end else if (clr_set_i) begin
      for (int w = 0; w < WAYS; w++) age_q[set_i][w] <= '0;
    end else if (clr_way_i) begin
      age_q[set_i][way_i] <= '0;
    end else if (touch_i) begin
      for (int w = 0; w < WAYS; w++)
        if (age_q[set_i][w] > age_q[set_i][way_i]) age_q[set_i][w] <= age_q[set_i][w] - 1'b1;
      age_q[set_i][way_i] <= AGE_MAX;
    end else if (fill_i) begin
      for (int w = 0; w < WAYS; w++)
        if (age_q[set_i][w] != '0) age_q[set_i][w] <= age_q[set_i][w] - 1'b1;
      age_q[set_i][way_i] <= AGE_MAX;
    end
  end
endmodule

// File: rtl/wt_dcache.sv
`timescale 1ns/1ps
module wt_dcache #(
  parameter int AW          = 32,
  parameter int WAYS        = 2,
  parameter int SETS        = 4,
  parameter int LINE_WORDS  = 4,
  parameter int AGE_STATES  = 4,
  parameter int LD_HIT_LAT  = 1,
  parameter int LD_MISS_LAT = 2,
  parameter int ST_HIT_LAT  = 0,
  parameter int ST_MISS_LAT = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cache_en,
  input  logic          cache_inhibit,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [1:0]    req_size,
  input  logic [AW-1:0] req_addr,
  input  logic [31:0]   req_wdata,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [31:0]   rsp_rdata,
  output logic          busy,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [3:0]    mem_be,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata
);
  import wtdc_pkg::*;

  localparam int SET_W   = $clog2(SETS);
  localparam int WAY_W   = $clog2(WAYS);
  localparam int WRD_W   = $clog2(LINE_WORDS);
  localparam int OFF_W   = WRD_W + 2;
  localparam int TAG_W   = AW - OFF_W - SET_W;
  localparam int LAT_A   = (LD_HIT_LAT > LD_MISS_LAT) ? LD_HIT_LAT : LD_MISS_LAT;
  localparam int LAT_B   = (ST_HIT_LAT > ST_MISS_LAT) ? ST_HIT_LAT : ST_MISS_LAT;
  localparam int LAT_MAX = (LAT_A > LAT_B) ? LAT_A : LAT_B;
  localparam int CNT_W   = $clog2(LAT_MAX + 1) + 1;

  typedef enum logic [2:0] {S_IDLE, S_LOOK, S_MEMRD, S_WRITE, S_REFILL, S_WAIT, S_RESP} state_e;

  state_e           state_q;
  logic [1:0]       op_q, size_q;
  logic [AW-1:0]    addr_q;
  logic [31:0]      wdata_q, rdata_q;
  logic             en_q, ci_q, hit_q;
  logic [WAY_W-1:0] way_q;
  logic [WRD_W-1:0] widx_q, beat_q;
  logic [CNT_W-1:0] cnt_q;

  logic [SET_W-1:0] set_idx;
  logic [TAG_W-1:0] tag;
  logic [WRD_W-1:0] req_word;
  logic             cacheable, hit;
  logic [WAY_W-1:0] hit_way, victim;
  logic [31:0]      rd_data, st_word;
  logic [3:0]       st_be;
  logic             dw_en, tw_en, tw_valid, clr_set;
  logic [WAY_W-1:0] dw_way, tw_way, age_way;
  logic [WRD_W-1:0] dw_word;
  logic [31:0]      dw_data;
  logic             age_touch, age_fill, age_clr;

  assign set_idx   = addr_q[OFF_W +: SET_W];
  assign tag       = addr_q[AW-1 -: TAG_W];
  assign req_word  = addr_q[2 +: WRD_W];
  assign cacheable = en_q && !ci_q;
  assign st_be     = lanes(size_q, addr_q[1:0]);
  assign st_word   = place(size_q, addr_q[1:0], wdata_q);

  wtdc_array #(.WAYS(WAYS), .SETS(SETS), .WORDS(LINE_WORDS), .TAG_W(TAG_W)) u_array (
    .clk(clk), .rst_n(rst_n), .set_i(set_idx), .tag_i(tag),
    .rd_way_i(way_q), .rd_word_i(req_word),
    .hit_o(hit), .hit_way_o(hit_way), .rd_data_o(rd_data),
    .dw_en_i(dw_en), .dw_way_i(dw_way), .dw_word_i(dw_word), .dw_data_i(dw_data),
    .tw_en_i(tw_en), .tw_valid_i(tw_valid), .tw_way_i(tw_way), .clr_set_i(clr_set)
  );

  wtdc_age #(.WAYS(WAYS), .SETS(SETS), .STATES(AGE_STATES)) u_age (
    .clk(clk), .rst_n(rst_n), .set_i(set_idx), .way_i(age_way),
    .touch_i(age_touch), .fill_i(age_fill), .clr_way_i(age_clr), .clr_set_i(clr_set),
    .victim_o(victim)
  );

  assign req_ready = (state_q == S_IDLE);
  assign busy      = (state_q != S_IDLE);
  assign rsp_valid = (state_q == S_RESP);
  assign rsp_rdata = rdata_q;
  assign mem_wdata = st_word;

  always_comb begin
    mem_req_valid = 1'b0;
    mem_we        = 1'b0;
    mem_be        = 4'hF;
    mem_addr      = {addr_q[AW-1:2], 2'b00};
    dw_en = 1'b0; dw_way = way_q; dw_word = req_word; dw_data = mem_rdata;
    tw_en = 1'b0; tw_valid = 1'b1; tw_way = way_q; clr_set = 1'b0;
    age_touch = 1'b0; age_fill = 1'b0; age_clr = 1'b0; age_way = way_q;
    case (state_q)
      S_LOOK: begin
        if (op_q == OP_INV) begin
          if (!en_q) clr_set = 1'b1;
          else if (hit) begin
            tw_en = 1'b1; tw_valid = 1'b0; tw_way = hit_way;
            age_clr = 1'b1; age_way = hit_way;
          end
        end else if (cacheable && hit) begin
          age_touch = 1'b1; age_way = hit_way;
        end
      end
      S_MEMRD: mem_req_valid = 1'b1;
      S_WRITE: begin
        mem_req_valid = 1'b1;
        mem_we        = 1'b1;
        mem_be        = st_be;
        if (mem_req_ready && cacheable && hit_q) begin
          dw_en   = 1'b1;
          dw_data = merge(rd_data, st_word, st_be);
        end
      end
      S_REFILL: begin
        mem_req_valid = 1'b1;
        mem_addr      = {addr_q[AW-1:OFF_W], widx_q, 2'b00};
        dw_en         = mem_req_ready;
        dw_word       = widx_q;
        if (mem_req_ready && beat_q == WRD_W'(LINE_WORDS - 1)) begin
          tw_en    = 1'b1;
          age_fill = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      op_q <= '0; size_q <= '0; addr_q <= '0; wdata_q <= '0; rdata_q <= '0;
      en_q <= 1'b0; ci_q <= 1'b0; hit_q <= 1'b0;
      way_q <= '0; widx_q <= '0; beat_q <= '0; cnt_q <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (req_valid) begin
          op_q <= req_op; size_q <= req_size; addr_q <= req_addr; wdata_q <= req_wdata;
          en_q <= cache_en; ci_q <= cache_inhibit; rdata_q <= '0;
          state_q <= S_LOOK;
        end
        S_LOOK: begin
          widx_q <= req_word;
          beat_q <= '0;
          if (op_q == OP_INV) begin
            cnt_q <= '0; state_q <= S_WAIT;
          end else if (op_q == OP_STORE) begin
            hit_q <= hit; way_q <= hit ? hit_way : victim; state_q <= S_WRITE;
          end else if (!cacheable) begin
            state_q <= S_MEMRD;
          end else if (hit) begin
            way_q <= hit_way; cnt_q <= CNT_W'(LD_HIT_LAT); state_q <= S_WAIT;
          end else begin
            way_q <= victim; cnt_q <= CNT_W'(LD_MISS_LAT); state_q <= S_REFILL;
          end
        end
        S_MEMRD: if (mem_req_ready) begin
          rdata_q <= extract(size_q, addr_q[1:0], mem_rdata);
          cnt_q <= '0; state_q <= S_WAIT;
        end
        S_WRITE: if (mem_req_ready) begin
          if (!cacheable) begin
            cnt_q <= '0; state_q <= S_WAIT;
          end else if (hit_q) begin
            cnt_q <= CNT_W'(ST_HIT_LAT); state_q <= S_WAIT;
          end else begin
            cnt_q <= CNT_W'(ST_MISS_LAT); state_q <= S_REFILL;
          end
        end
        S_REFILL: if (mem_req_ready) begin
          widx_q <= widx_q + 1'b1;
          beat_q <= beat_q + 1'b1;
          if (beat_q == WRD_W'(LINE_WORDS - 1)) state_q <= S_WAIT;
        end
        S_WAIT: begin
          if (cnt_q == '0) begin
            if (op_q == OP_LOAD && cacheable) rdata_q <= extract(size_q, addr_q[1:0], rd_data);
            state_q <= S_RESP;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        S_RESP: if (rsp_ready) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wt_dcache_chk.sv
`timescale 1ns/1ps
module wt_dcache_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          busy,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [31:0]   rsp_rdata,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [3:0]    mem_be
);
  AST_MEM_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_addr) && $stable(mem_we)); // R12
  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata)); // R12
  AST_MEM_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> busy && !req_ready && !rsp_valid); // R12
  AST_BE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_we |-> (mem_be inside {4'h8, 4'h4, 4'h2, 4'h1, 4'hC, 4'h3, 4'hF})); // R5
  AST_IDLE_AFTER_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_ready |=> req_ready && !busy); // R12
endmodule

bind wt_dcache wt_dcache_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .busy(busy),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be)
);

// File: tb/wt_dcache_bench.sv
`timescale 1ns/1ps
module wt_dcache_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cache_en = 1'b1, cache_inhibit = 1'b0;
  logic        req_valid = 1'b0, rsp_ready = 1'b1;
  logic [1:0]  req_op = '0, req_size = '0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic        req_ready, rsp_valid, busy, mem_req_valid, mem_we, mem_req_ready;
  logic [31:0] rsp_rdata, mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_be;

  logic [31:0] mem [64];
  logic        stall = 1'b0, tick = 1'b0, log_en = 1'b0;
  logic [31:0] rlog [8];
  int          nlog = 0;
  int          n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  wt_dcache u_wt_dcache (.*);

  always @(posedge clk) tick <= ~tick;
  assign mem_req_ready = !stall || tick;
  assign mem_rdata     = mem[mem_addr[7:2]];

  always @(negedge clk) begin
    if (mem_req_valid && mem_req_ready && mem_we)
      for (int i = 0; i < 4; i++) if (mem_be[i]) mem[mem_addr[7:2]][8*i +: 8] = mem_wdata[8*i +: 8];
    if (mem_req_valid && mem_req_ready && !mem_we && log_en && nlog < 8) begin
      rlog[nlog] = mem_addr; nlog++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_ld(input logic [1:0] sz, input logic [7:0] a);
    logic [31:0] w;
    w = mem[a[7:2]];
    case (sz)
      2'd0: ref_ld = (w >> (24 - 8 * a[1:0])) & 32'hFF;
      2'd1: ref_ld = a[1] ? (w & 32'hFFFF) : (w >> 16);
      default: ref_ld = w;
    endcase
  endfunction

  task automatic do_op(input logic [1:0] op, input logic [1:0] sz, input logic [7:0] a,
                       input logic [31:0] wd, output int lat, output logic [31:0] rd);
    req_op = op; req_size = sz; req_addr = {24'd0, a}; req_wdata = wd; req_valid = 1'b1;
    @(posedge clk); #1 req_valid = 1'b0;
    lat = 0;
    while (lat < 500) begin
      @(posedge clk); lat++; #1;
      if (rsp_valid) break;
    end
    rd = rsp_rdata;
    @(posedge clk); @(negedge clk);
  endtask

  // {op, size, addr, wdata, expected latency}
  localparam logic [51:0] VEC [16] = '{
    {2'd0, 2'd2, 8'h04, 32'h0,        8'd8},
    {2'd0, 2'd2, 8'h0C, 32'h0,        8'd3},
    {2'd0, 2'd0, 8'h09, 32'h0,        8'd3},
    {2'd0, 2'd1, 8'h0A, 32'h0,        8'd3},
    {2'd1, 2'd0, 8'h05, 32'h000000EE, 8'd3},
    {2'd0, 2'd2, 8'h04, 32'h0,        8'd3},
    {2'd1, 2'd1, 8'h0E, 32'h0000BEEF, 8'd3},
    {2'd0, 2'd2, 8'h0C, 32'h0,        8'd3},
    {2'd1, 2'd2, 8'h48, 32'hDEADBEEF, 8'd8},
    {2'd0, 2'd2, 8'h40, 32'h0,        8'd3},
    {2'd0, 2'd2, 8'h84, 32'h0,        8'd8},
    {2'd0, 2'd2, 8'h00, 32'h0,        8'd8},
    {2'd0, 2'd2, 8'h80, 32'h0,        8'd3},
    {2'd0, 2'd2, 8'h44, 32'h0,        8'd8},
    {2'd2, 2'd2, 8'h80, 32'h0,        8'd2},
    {2'd0, 2'd2, 8'h80, 32'h0,        8'd8}
  };

  initial begin : watchdog
    #250000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int lat;
    logic [31:0] rd, old4, old5, oldx;
    for (int i = 0; i < 64; i++) mem[i] = 32'h0011_2233 + i * 32'h0404_0404;
    repeat (3) @(negedge clk);
    // R13 reset state
    chk("R13 busy", {31'd0, busy}, 32'd0);
    chk("R13 req_ready", {31'd0, req_ready}, 32'd1);
    chk("R13 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    chk("R13 mem_req_valid", {31'd0, mem_req_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // table: R1 R2 R3 R5 R6 R8 R9 R11
    for (int k = 0; k < 16; k++) begin
      do_op(VEC[k][51:50], VEC[k][49:48], VEC[k][47:40], VEC[k][39:8], lat, rd);
      chk($sformatf("R11/R8 latency row %0d", k), lat, {24'd0, VEC[k][7:0]});
      if (VEC[k][51:50] == 2'd0)
        chk($sformatf("R2 load data row %0d", k), rd, ref_ld(VEC[k][49:48], VEC[k][47:40]));
    end
    chk("R5 byte lane in memory", {24'd0, mem[1][23:16]}, 32'hEE);
    chk("R5 half lane in memory", {16'd0, mem[3][15:0]}, 32'hBEEF);
    chk("R6 store miss wrote memory", mem[18], 32'hDEADBEEF);

    // R4 bypass with caching off, cache left as it was
    do_op(2'd0, 2'd2, 8'h10, 0, lat, rd);
    chk("R3 miss latency", lat, 8);
    old4 = mem[4];
    mem[4] = 32'hCAFE_F00D;
    do_op(2'd0, 2'd2, 8'h10, 0, lat, rd);
    chk("R1 hit returns cached copy", rd, old4);
    cache_en = 1'b0;
    do_op(2'd0, 2'd2, 8'h10, 0, lat, rd);
    chk("R4 disabled load data", rd, 32'hCAFE_F00D);
    chk("R4 disabled load latency", lat, 3);
    cache_en = 1'b1; cache_inhibit = 1'b1;
    do_op(2'd0, 2'd1, 8'h12, 0, lat, rd);
    chk("R4 inhibited half load", rd, 32'h0000_F00D);
    cache_inhibit = 1'b0;
    do_op(2'd0, 2'd2, 8'h10, 0, lat, rd);
    chk("R4 cache unchanged after bypass", rd, old4);

    // R7 uncached store leaves cached copy
    old5 = mem[5];
    cache_inhibit = 1'b1;
    do_op(2'd1, 2'd2, 8'h14, 32'h1122_3344, lat, rd);
    cache_inhibit = 1'b0;
    chk("R5 uncached store reaches memory", mem[5], 32'h1122_3344);
    chk("R11 uncached store latency", lat, 3);
    do_op(2'd0, 2'd2, 8'h14, 0, lat, rd);
    chk("R7 cached word kept", rd, old5);

    // R9 / R10 invalidate
    do_op(2'd0, 2'd2, 8'h20, 0, lat, rd);
    do_op(2'd0, 2'd2, 8'h60, 0, lat, rd);
    oldx = mem[8];
    mem[8]  = 32'hAAAA_0008;
    mem[24] = 32'hBBBB_0018;
    do_op(2'd2, 2'd2, 8'hE0, 0, lat, rd);
    do_op(2'd0, 2'd2, 8'h20, 0, lat, rd);
    chk("R9 missing invalidate keeps line", rd, oldx);
    cache_en = 1'b0;
    do_op(2'd2, 2'd2, 8'hA0, 0, lat, rd);
    cache_en = 1'b1;
    chk("R11 invalidate latency", lat, 2);
    do_op(2'd0, 2'd2, 8'h20, 0, lat, rd);
    chk("R10 way A cleared data", rd, 32'hAAAA_0008);
    chk("R10 way A cleared latency", lat, 8);
    do_op(2'd0, 2'd2, 8'h60, 0, lat, rd);
    chk("R10 way B cleared data", rd, 32'hBBBB_0018);
    chk("R10 way B cleared latency", lat, 8);

    // R3 wrapped refill order under memory back-pressure, R12 busy
    stall = 1'b1; nlog = 0; log_en = 1'b1;
    req_op = 2'd0; req_size = 2'd2; req_addr = 32'h38; req_valid = 1'b1;
    @(posedge clk); #1 req_valid = 1'b0;
    chk("R12 busy while in flight", {30'd0, busy, req_ready}, 32'd2);
    while (!rsp_valid && nlog < 100) @(negedge clk);
    chk("R3 load data under stall", rsp_rdata, mem[14]);
    @(posedge clk); @(negedge clk);
    log_en = 1'b0;
    chk("R3 beat count", nlog, 4);
    chk("R3 first beat", rlog[0], 32'h38);
    chk("R3 second beat", rlog[1], 32'h3C);
    chk("R3 wrap beat", rlog[2], 32'h30);
    chk("R3 last beat", rlog[3], 32'h34);
    do_op(2'd1, 2'd1, 8'h3A, 32'h0000_1234, lat, rd);
    chk("R5 half store memory lanes", mem[14], {oldx[31:0] & 32'h0, mem[14][31:16], 16'h1234});
    do_op(2'd0, 2'd1, 8'h3A, 0, lat, rd);
    chk("R5 merged half from cache", rd, 32'h1234);
    do_op(2'd0, 2'd1, 8'h38, 0, lat, rd);
    chk("R5 other half kept", rd, ref_ld(2'd1, 8'h38));
    stall = 1'b0;

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule